// File: doc/BRIEF.md
# Configurable-Sense Interrupt Controller

This block gathers 32 interrupt request lines and turns them into two request outputs for a processor: one for critical work and one for ordinary work. Each line can be set up on its own to react to a level or to an edge, and to a high or a low sense. Any detected event is held in a pending register until software acknowledges it by writing a one to its bit. An enable register decides which pending events may reach the outputs. A routing register picks which of the two outputs each line drives.

Software reaches the block over a simple register bus that uses word indexes. Reads return data one cycle after the request. A third output rises whenever either request output is high. A parent controller can use it as one of its own inputs, so several of these blocks can be chained.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable, routing, sense-polarity and trigger-mode registers read zero, and all three request outputs are low.
- R2: Source n uses bit (31 − n) of every register and of the `src_i` vector, so source 0 is bit 31. The register word indexes are: pending 0, enable 2, routing 3, polarity 4, trigger mode 5, masked pending 6.
- R3: A source whose trigger bit is 0 is level sensed. With polarity 1 it is active high, and with polarity 0 it is active low. Its pending bit sets while the synchronised input is at the active level.
- R4: A source whose trigger bit is 1 is edge sensed. With polarity 1 it reacts to a rising edge, and with polarity 0 to a falling edge. Each such edge sets the pending bit once. A steady input or a change of polarity sets nothing.
- R5: A write to index 0 clears every pending bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears every pending bit that has no new event.
- R6: When a new event and a clearing write hit the same pending bit in one cycle, the bit stays set. A level source that is still active therefore cannot be cleared.
- R7: Index 6 reads the pending register ANDed with the enable register.
- R8: The ordinary output is the registered OR of the masked pending bits whose routing bit is 0. The critical output is the same for routing bit 1. Each output follows its pending bits with one register stage.
- R9: The cascade output is high exactly when the critical or the ordinary output is high.
- R10: Read data appears in the cycle after a read request. It shows register contents from before any write in the same cycle. Indexes 1 and 7 to 15 read zero, and read data is zero in a cycle with no read request the cycle before.
- R11: Writes to index 6 and to the unused indexes change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt request lines, source n on bit 31−n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_crit_o | output | 1 | Critical interrupt request |
| irq_noncrit_o | output | 1 | Ordinary interrupt request |
| irq_any_o | output | 1 | Cascade flag for a parent controller |

## Verification
Level sources are driven with high-active and low-active settings and are held active through a clearing write. This separates a true level latch from a one-shot latch, and it shows the set-over-clear priority. Edge sources see a rising pulse, a polarity change under a steady high input, and a falling edge. These tell a real edge apart from a polarity flip and from a level. Enable and routing settings are changed with a source pending, to show which output each bit reaches. Writes to the read-only and unused indexes are followed by reads of the registers they could have changed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned IRQ_NUM    = 32;
    localparam int unsigned IRQ_ADDR_W = 4;

    // Register word indexes
    localparam logic [IRQ_ADDR_W-1:0] IDX_PEND = 4'd0;
    localparam logic [IRQ_ADDR_W-1:0] IDX_EN   = 4'd2;
    localparam logic [IRQ_ADDR_W-1:0] IDX_ROUTE = 4'd3;
    localparam logic [IRQ_ADDR_W-1:0] IDX_POL  = 4'd4;
    localparam logic [IRQ_ADDR_W-1:0] IDX_TRIG = 4'd5;
    localparam logic [IRQ_ADDR_W-1:0] IDX_MASK = 4'd6;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_i;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_sense.sv
module irqc_sense #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] trig_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] act_now, act_prev;

    always_comb begin
        prev_d   = lvl_i;
        // polarity 1: high is active; polarity 0: low is active
        act_now  = ~(lvl_i ^ pol_i);
        act_prev = ~(prev_q ^ pol_i);
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (trig_i[i]) evt_o[i] = act_now[i] & ~act_prev[i];
            else           evt_o[i] = act_now[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  evt_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    output logic [W-1:0]  pend_o,
    output logic [W-1:0]  en_o,
    output logic [W-1:0]  route_o,
    output logic [W-1:0]  pol_o,
    output logic [W-1:0]  trig_o,
    output logic          irq_crit_o,
    output logic          irq_noncrit_o,
    output logic          irq_any_o
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic [W-1:0] route;
        logic [W-1:0] pol;
        logic [W-1:0] trig;
        logic [W-1:0] rdata;
        logic         crit;
        logic         noncrit;
        logic         any;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] masked;
    logic [W-1:0] clr;
    logic [W-1:0] rd_val;
    logic         hit_pend, hit_en, hit_route, hit_pol, hit_trig;

    always_comb begin
        masked    = st_q.pend & st_q.en;
        hit_pend  = wr_en_i && (addr_i == AW'(IDX_PEND));
        hit_en    = wr_en_i && (addr_i == AW'(IDX_EN));
        hit_route = wr_en_i && (addr_i == AW'(IDX_ROUTE));
        hit_pol   = wr_en_i && (addr_i == AW'(IDX_POL));
        hit_trig  = wr_en_i && (addr_i == AW'(IDX_TRIG));
        clr       = hit_pend ? wdata_i : '0;

        case (addr_i)
            AW'(IDX_PEND):  rd_val = st_q.pend;
            AW'(IDX_EN):    rd_val = st_q.en;
            AW'(IDX_ROUTE): rd_val = st_q.route;
            AW'(IDX_POL):   rd_val = st_q.pol;
            AW'(IDX_TRIG):  rd_val = st_q.trig;
            AW'(IDX_MASK):  rd_val = masked;
            default:        rd_val = '0;
        endcase

        st_d       = st_q;
        // a new event outranks a clearing write
        st_d.pend  = (st_q.pend & ~clr) | evt_i;
        if (hit_en)    st_d.en    = wdata_i;
        if (hit_route) st_d.route = wdata_i;
        if (hit_pol)   st_d.pol   = wdata_i;
        if (hit_trig)  st_d.trig  = wdata_i;
        st_d.rdata   = rd_en_i ? rd_val : '0;
        st_d.crit    = |(masked & st_q.route);
        st_d.noncrit = |(masked & ~st_q.route);
        st_d.any     = |masked;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o       = st_q.rdata;
    assign pend_o        = st_q.pend;
    assign en_o          = st_q.en;
    assign route_o       = st_q.route;
    assign pol_o         = st_q.pol;
    assign trig_o        = st_q.trig;
    assign irq_crit_o    = st_q.crit;
    assign irq_noncrit_o = st_q.noncrit;
    assign irq_any_o     = st_q.any;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = IRQ_NUM,
    parameter int unsigned ADDR_W      = IRQ_ADDR_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               irq_crit_o,
    output logic               irq_noncrit_o,
    output logic               irq_any_o
);
    logic [NUM_SRC-1:0] sync_w, evt_w, pend_w, en_w, route_w, pol_w, trig_w;

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (sync_w)
    );

    irqc_sense #(.W(NUM_SRC)) u_sense (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (sync_w),
        .pol_i  (pol_w),
        .trig_i (trig_w),
        .evt_o  (evt_w)
    );

    irqc_regs #(.W(NUM_SRC), .AW(ADDR_W)) u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .evt_i         (evt_w),
        .wr_en_i       (wr_en_i),
        .rd_en_i       (rd_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .rdata_o       (rdata_o),
        .pend_o        (pend_w),
        .en_o          (en_w),
        .route_o       (route_w),
        .pol_o         (pol_w),
        .trig_o        (trig_w),
        .irq_crit_o    (irq_crit_o),
        .irq_noncrit_o (irq_noncrit_o),
        .irq_any_o     (irq_any_o)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic          rd_en_i,
    input logic [AW-1:0] addr_i,
    input logic [W-1:0]  wdata_i,
    input logic [W-1:0]  rdata_o,
    input logic          irq_crit_o,
    input logic          irq_noncrit_o,
    input logic          irq_any_o,
    input logic [W-1:0]  sync_w,
    input logic [W-1:0]  evt_w,
    input logic [W-1:0]  pend_w,
    input logic [W-1:0]  en_w,
    input logic [W-1:0]  route_w,
    input logic [W-1:0]  pol_w,
    input logic [W-1:0]  trig_w
);
    // R3
    level_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~trig_w & ~(sync_w ^ pol_w) & ~evt_w) == '0));

    // R5
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == AW'(IDX_PEND)) |=> ((pend_w & $past(wdata_i) & ~$past(evt_w)) == '0));

    // R6
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_w != '0) |=> ((pend_w & $past(evt_w)) == $past(evt_w)));

    // R7
    masked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == AW'(IDX_MASK)) |=> (rdata_o == $past(pend_w & en_w)));

    // R8
    crit_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (irq_crit_o == $past(|(pend_w & en_w & route_w))));

    // R8
    noncrit_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (irq_noncrit_o == $past(|(pend_w & en_w & ~route_w))));

    // R9
    cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_any_o == (irq_crit_o | irq_noncrit_o));

    // R10
    idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rdata_o == '0));
endmodule

bind irq_ctrl irqc_chk #(.W(NUM_SRC), .AW(ADDR_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .rd_en_i       (rd_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .rdata_o       (rdata_o),
    .irq_crit_o    (irq_crit_o),
    .irq_noncrit_o (irq_noncrit_o),
    .irq_any_o     (irq_any_o),
    .sync_w        (sync_w),
    .evt_w         (evt_w),
    .pend_w        (pend_w),
    .en_w          (en_w),
    .route_w       (route_w),
    .pol_w         (pol_w),
    .trig_w        (trig_w)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ic, inc, ia;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr), .rd_en_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_crit_o(ic), .irq_noncrit_o(inc), .irq_any_o(ia)
    );

    // behavioural reference model
    bit [31:0] m_s1, m_s2, m_prev, m_pend, m_en, m_route, m_pol, m_trig, m_rdata;
    bit        m_crit, m_nc, m_any;

    function automatic bit [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return m_pend;
            4'd2: return m_en;
            4'd3: return m_route;
            4'd4: return m_pol;
            4'd5: return m_trig;
            4'd6: return m_pend & m_en;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [31:0] ev;
        bit [31:0] clr;
        bit [31:0] msk;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_en = 0; m_route = 0;
            m_pol = 0; m_trig = 0; m_rdata = 0; m_crit = 0; m_nc = 0; m_any = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                bit now_act;
                bit old_act;
                now_act = (m_s2[i] == m_pol[i]);
                old_act = (m_prev[i] == m_pol[i]);
                ev[i] = m_trig[i] ? (now_act && !old_act) : now_act;
            end
            msk = m_pend & m_en;
            m_crit = (msk & m_route) != 0;
            m_nc   = (msk & ~m_route) != 0;
            m_any  = msk != 0;
            m_rdata = rd ? model_read(addr) : 32'h0;
            clr = (wr && addr == 4'd0) ? wdata : 32'h0;
            m_pend = (m_pend & ~clr) | ev;
            if (wr && addr == 4'd2) m_en = wdata;
            if (wr && addr == 4'd3) m_route = wdata;
            if (wr && addr == 4'd4) m_pol = wdata;
            if (wr && addr == 4'd5) m_trig = wdata;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = src;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R10 rdata vs model", rdata, m_rdata);
            check("R8 crit vs model", {31'b0, ic}, {31'b0, m_crit});
            check("R8 noncrit vs model", {31'b0, inc}, {31'b0, m_nc});
            check("R9 cascade vs model", {31'b0, ia}, {31'b0, m_any});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 crit after reset", {31'b0, ic}, 32'h0);
        check("R1 cascade after reset", {31'b0, ia}, 32'h0);
        rd_chk(4'd2, 32'h0, "R1 enable");
        rd_chk(4'd3, 32'h0, "R1 routing");
        rd_chk(4'd4, 32'h0, "R1 polarity");
        rd_chk(4'd5, 32'h0, "R1 trigger");

        // all active high, clear what latched while inputs were low
        wr_reg(4'd4, 32'hFFFF_FFFF);
        tick(3);
        wr_reg(4'd0, 32'hFFFF_FFFF);
        rd_chk(4'd0, 32'h0, "R5 clear all");

        // R2 R3 source 0 on bit 31, level high
        src = 32'h8000_0000;
        tick(4);
        rd_chk(4'd0, 32'h8000_0000, "R2 R3 level latch source 0");
        rd_chk(4'd6, 32'h0, "R7 masked while disabled");
        check("R8 no output while disabled", {31'b0, inc}, 32'h0);

        wr_reg(4'd2, 32'h8000_0000);
        tick(2);
        check("R8 noncrit asserted", {31'b0, inc}, 32'h1);
        check("R8 crit stays low", {31'b0, ic}, 32'h0);
        check("R9 cascade high", {31'b0, ia}, 32'h1);
        rd_chk(4'd6, 32'h8000_0000, "R7 masked pending");

        // R6 active level cannot be cleared
        wr_reg(4'd0, 32'h8000_0000);
        rd_chk(4'd0, 32'h8000_0000, "R6 level relatch");

        src = 32'h0;
        tick(4);
        wr_reg(4'd0, 32'h8000_0000);
        rd_chk(4'd0, 32'h0, "R3 cleared after release");
        tick(2);
        check("R8 noncrit drops", {31'b0, inc}, 32'h0);

        // R4 edge sensing on source 31 (bit 0)
        wr_reg(4'd5, 32'h0000_0001);
        src = 32'h0000_0001;
        tick(4);
        rd_chk(4'd0, 32'h0000_0001, "R4 rising edge");
        wr_reg(4'd0, 32'h0000_0001);
        tick(3);
        rd_chk(4'd0, 32'h0, "R4 steady high no relatch");
        wr_reg(4'd4, 32'hFFFF_FFFE);
        tick(3);
        rd_chk(4'd0, 32'h0, "R4 polarity change no event");
        src = 32'h0;
        tick(4);
        rd_chk(4'd0, 32'h0000_0001, "R4 falling edge");

        // R5 writing zero leaves the bit
        wr_reg(4'd0, 32'h0);
        rd_chk(4'd0, 32'h0000_0001, "R5 zero write keeps");

        // R8 critical routing
        wr_reg(4'd3, 32'h0000_0001);
        wr_reg(4'd2, 32'h0000_0001);
        tick(2);
        check("R8 crit asserted", {31'b0, ic}, 32'h1);
        check("R8 noncrit low when routed crit", {31'b0, inc}, 32'h0);

        // R11 read-only and unused indexes
        wr_reg(4'd6, 32'hFFFF_FFFF);
        rd_chk(4'd2, 32'h0000_0001, "R11 enable untouched");
        rd_chk(4'd6, 32'h0000_0001, "R11 masked untouched");
        wr_reg(4'd7, 32'hFFFF_FFFF);
        wr_reg(4'd1, 32'hFFFF_FFFF);
        rd_chk(4'd3, 32'h0000_0001, "R11 routing untouched");
        rd_chk(4'd7, 32'h0, "R10 index 7 zero");
        rd_chk(4'd1, 32'h0, "R10 index 1 zero");
        rd_chk(4'd8, 32'h0, "R10 index 8 zero");
        rd_chk(4'd15, 32'h0, "R10 index 15 zero");

        wr_reg(4'd0, 32'hFFFF_FFFF);
        rd_chk(4'd0, 32'h0, "R5 clear all again");
        tick(2);
        check("R8 crit drops", {31'b0, ic}, 32'h0);
        check("R9 cascade drops", {31'b0, ia}, 32'h0);

        tick(2);
        finish_run();
    end
endmodule